// File: doc/BRIEF.md
# SPI Nonvolatile Memory Command Engine

This block is the serial front end of a byte-addressed memory with a 17-bit address space. It watches the SPI slave pins (chip select, serial clock, serial data in and a hold pin), decodes one 8-bit command per chip-select assertion, and turns it into actions on three neighbours. The first is a simple synchronous memory port. The second is a status unit that owns the write-enable latch and the status byte. The third is a sequencer for store, recall and automatic-store control. The protection policy, the memory array and the nonvolatile sequencing sit outside the block.

All pins are sampled by the system clock. The serial clock must stay high for at least 8 system clocks, and low for at least 8 system clocks. The controller is a state machine with these states:

- `ST_DESEL`: deselected.
- `ST_OPCODE`: collecting the command byte.
- `ST_ADDR`: collecting the address bytes.
- `ST_WDATA`: burst write.
- `ST_RDATA`: burst read.
- `ST_SRWR`: collecting the status byte to write.
- `ST_SRRD`: repeating status read.
- `ST_ARMED`: a command is complete and waits for chip select to rise.
- `ST_DISCARD`: the opcode was unknown or reserved.

The state machine moves as follows:

- Any state goes to `ST_DESEL` when chip select rises.
- `ST_DESEL` goes to `ST_OPCODE` when chip select falls.
- At the end of the command byte, `ST_OPCODE` moves to one of `ST_ARMED`, `ST_SRWR`, `ST_SRRD`, `ST_ADDR` or `ST_DISCARD`, depending on the opcode.
- At the end of the last address byte, `ST_ADDR` moves to `ST_RDATA` or `ST_WDATA`.
- At the end of its data byte, `ST_SRWR` moves to `ST_ARMED`.

Both idle clock levels are accepted. The level of the serial clock when chip select falls fixes the mode: low is mode 0 and high is mode 3. In both modes, input bits are taken on rising clock edges and output bits change on falling edges. In mode 3, the falling edge that opens the first bit does not shift the output.

Top module: `spi_nv_engine`

## Requirements
- R1: After reset the engine is deselected. Chip select must be seen high and then low before any command is taken. Bits clocked while chip select has stayed low since reset produce no request and no memory access, and `so_oe` stays 0.
- R2: While deselected, serial clock and data-in activity has no effect and `so_oe` is 0.
- R3: The opcode-only commands act as follows, each as a one-cycle pulse issued when chip select rises after a complete opcode byte:
  - 0x06 gives `sr_req_valid` with `sr_req_kind` 0 (set write enable).
  - 0x04 gives `sr_req_kind` 1 (clear write enable).
  - 0x3C gives `nv_req_valid` with `nv_req_kind` 0 (store).
  - 0x60 gives `nv_req_kind` 1 (recall).
  - 0x59 gives `nv_req_kind` 2 (automatic store on).
  - 0x19 gives `nv_req_kind` 3 (automatic store off).
- R4: Opcode 0x01 followed by one byte gives, at chip-select rise, `sr_req_valid` with `sr_req_kind` 2 and `sr_req_data` equal to that byte. Opcode 0x05 shifts `sr_rdata` out MSB first, and reloads it for every further byte while chip select stays low.
- R5: Opcode 0x03 takes three address bytes, MSB first. Only the low 17 bits of the 24 received are used. Memory bytes are then returned MSB first on `so`, with the address stepping by one after each byte.
- R6: Opcode 0x02 takes three address bytes. Each complete data byte that follows gives one `mem_wr_en` pulse at the current address, and the address then steps by one.
- R7: In a burst, the address after 0x1FFFF is 0x00000.
- R8: When chip select rises in the middle of a byte, that byte is dropped. A partial opcode issues nothing, a partial write byte writes nothing, and a partial status data byte issues nothing.
- R9: Opcode 0x1E, and any other opcode not listed, causes no request and no memory access, and `so_oe` stays 0 until chip select rises.
- R10: Only the first byte after a chip-select fall is decoded as an opcode. Bytes that follow an opcode-only command are ignored.
- R11: While selected, `hold_n` low forces `so_oe` to 0 and makes the engine ignore serial clock edges. Releasing it resumes the same transfer with no bit lost.
- R12: A command framed with the serial clock high at chip-select fall (mode 3) behaves exactly as in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_addr | output | 17 | Memory address |
| mem_rd_en | output | 1 | Memory read strobe; data returns on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| sr_rdata | input | 8 | Current status byte |
| sr_req_valid | output | 1 | Status request pulse |
| sr_req_kind | output | 2 | 0 set write enable, 1 clear write enable, 2 write status |
| sr_req_data | output | 8 | Byte for a status write |
| nv_req_valid | output | 1 | Nonvolatile request pulse |
| nv_req_kind | output | 2 | 0 store, 1 recall, 2 automatic store on, 3 automatic store off |

## Verification
The hardest case to reach from the pins is a hold pause in the middle of a read byte. It has to land between a real output shift edge and the next sampling edge. The clock is then toggled while hold is low, and the bench shows that no bit was skipped or repeated. The driver task accepts a byte and bit index at which it pulls hold low with the clock low. It then pulses the clock with inverted data, restores the data bit and releases hold. Two other cases share this driver and are just as hard to set up: chip select rising partway through a byte, and a burst crossing the top address. The driver can stop a byte after any number of bits, and it sends address bytes with spare high bits set.

// File: rtl/spi_nv_pkg.sv
package spi_nv_pkg;

    typedef enum logic [3:0] {
        ST_DESEL,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SRWR,
        ST_SRRD,
        ST_ARMED,
        ST_DISCARD
    } ctrl_state_t;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_STORE  = 8'h3C;
    localparam logic [7:0] OP_RECALL = 8'h60;
    localparam logic [7:0] OP_ASON   = 8'h59;
    localparam logic [7:0] OP_ASOFF  = 8'h19;

    localparam logic [1:0] SRK_SET   = 2'd0;
    localparam logic [1:0] SRK_CLR   = 2'd1;
    localparam logic [1:0] SRK_WRITE = 2'd2;

    localparam logic [1:0] NVK_STORE  = 2'd0;
    localparam logic [1:0] NVK_RECALL = 2'd1;
    localparam logic [1:0] NVK_ASON   = 2'd2;
    localparam logic [1:0] NVK_ASOFF  = 2'd3;

endpackage

// File: rtl/spi_nv_pins.sv
// Samples the serial pins, finds chip-select and clock edges, and gates
// clock edges by selection, hold and the mode-3 dummy falling edge.
module spi_nv_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic selected,
    output logic hold_on
);
    logic cs_s, cs_d, sck_s, sck_d, hold_s, sel_q, mask_q;
    logic raw_rise, raw_fall, gate;

    // cs history resets low, so a high-then-low sequence is needed first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s   <= 1'b0;
            cs_d   <= 1'b0;
            sck_s  <= 1'b0;
            sck_d  <= 1'b0;
            si_s   <= 1'b0;
            hold_s <= 1'b1;
        end else begin
            cs_s   <= cs_n;
            cs_d   <= cs_s;
            sck_s  <= sck;
            sck_d  <= sck_s;
            si_s   <= si;
            hold_s <= hold_n;
        end
    end

    assign cs_fall  = cs_d & ~cs_s;
    assign cs_rise  = sel_q & cs_s & ~cs_d;
    assign raw_rise = sck_s & ~sck_d;
    assign raw_fall = ~sck_s & sck_d;
    assign gate     = sel_q & hold_s & ~cs_s;
    assign sck_rise = gate & raw_rise;
    assign sck_fall = gate & raw_fall & ~mask_q;
    assign selected = sel_q;
    assign hold_on  = sel_q & ~hold_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (cs_fall)
                sel_q <= 1'b1;
            else if (cs_rise)
                sel_q <= 1'b0;
            // mode 3: clock high at selection, first falling edge is a dummy
            if (cs_fall)
                mask_q <= sck_s;
            else if (gate && raw_fall)
                mask_q <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_nv_shift.sv
// Receive and transmit shift registers with the bit counter.
module spi_nv_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         rise,
    input  logic         fall,
    input  logic         si,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic         byte_done,
    output logic [W-1:0] rx_byte,
    output logic         so_bit
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt_q;
    logic [W-2:0]  rx_q;
    logic [W-1:0]  tx_q;
    logic          so_q;

    assign rx_byte   = {rx_q, si};
    assign byte_done = rise & (cnt_q == CW'(W - 1));
    assign so_bit    = so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (rise) begin
            rx_q  <= rx_byte[W-2:0];
            cnt_q <= (cnt_q == CW'(W - 1)) ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            so_q <= 1'b0;
        end else if (ld) begin
            tx_q <= ld_data;
        end else if (fall) begin
            so_q <= tx_q[W-1];
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_nv_ctrl.sv
// Command state machine: opcode decode, address collection, bursts and
// request issue at chip-select rise.
module spi_nv_ctrl
    import spi_nv_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic              hold_on,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        sr_rdata,
    output logic              ld,
    output logic [7:0]        ld_data,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    output logic              sr_req_valid,
    output logic [1:0]        sr_req_kind,
    output logic [7:0]        sr_req_data,
    output logic              nv_req_valid,
    output logic [1:0]        nv_req_kind
);
    localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    ctrl_state_t       state_q, state_d;
    logic [7:0]        op_q;
    logic [ACW-1:0]    acnt_q;
    logic [ADDR_W-9:0] ash_q;
    logic [ADDR_W-1:0] afull;
    logic              alast;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q, wr_q, inc_q, rd_pend_q;
    logic [7:0]        wdata_q, srd_q;
    logic              srv_q, nvv_q;
    logic [1:0]        srk_q, nvk_q;

    // upper address bits beyond ADDR_W fall off the top of this shift
    assign afull = {ash_q, rx_byte};
    assign alast = (acnt_q == ACW'(ADDR_BYTES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_rise) begin
            state_d = ST_DESEL;
        end else if (cs_fall) begin
            state_d = ST_OPCODE;
        end else if (byte_done) begin
            unique case (state_q)
                ST_OPCODE: begin
                    case (rx_byte)
                        OP_WREN, OP_WRDI, OP_STORE,
                        OP_RECALL, OP_ASON, OP_ASOFF: state_d = ST_ARMED;
                        OP_WRSR:                      state_d = ST_SRWR;
                        OP_RDSR:                      state_d = ST_SRRD;
                        OP_READ, OP_WRITE:            state_d = ST_ADDR;
                        default:                      state_d = ST_DISCARD;
                    endcase
                end
                ST_ADDR: begin
                    if (alast)
                        state_d = (op_q == OP_READ) ? ST_RDATA : ST_WDATA;
                end
                ST_SRWR: state_d = ST_ARMED;
                default: state_d = state_q;
            endcase
        end
    end

    // transmit loads: memory data one cycle after a read, status on RDSR
    assign ld = rd_pend_q |
                (byte_done & (((state_q == ST_OPCODE) && (rx_byte == OP_RDSR)) ||
                              (state_q == ST_SRRD)));
    assign ld_data = rd_pend_q ? mem_rdata : sr_rdata;
    assign so_oe   = ((state_q == ST_RDATA) || (state_q == ST_SRRD)) & ~hold_on;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            acnt_q    <= '0;
            ash_q     <= '0;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            inc_q     <= 1'b0;
            rd_pend_q <= 1'b0;
            wdata_q   <= '0;
            srd_q     <= '0;
            srv_q     <= 1'b0;
            nvv_q     <= 1'b0;
            srk_q     <= '0;
            nvk_q     <= '0;
        end else begin
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            inc_q     <= 1'b0;
            srv_q     <= 1'b0;
            nvv_q     <= 1'b0;
            rd_pend_q <= rd_q;
            if (inc_q)
                addr_q <= addr_q + ADDR_W'(1);
            if (cs_fall)
                acnt_q <= '0;
            if (byte_done) begin
                unique case (state_q)
                    ST_OPCODE: op_q <= rx_byte;
                    ST_ADDR: begin
                        ash_q  <= afull[ADDR_W-9:0];
                        acnt_q <= acnt_q + ACW'(1);
                        if (alast) begin
                            addr_q <= afull;
                            if (op_q == OP_READ) rd_q <= 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        addr_q <= addr_q + ADDR_W'(1);
                        rd_q   <= 1'b1;
                    end
                    ST_WDATA: begin
                        wr_q    <= 1'b1;
                        wdata_q <= rx_byte;
                        inc_q   <= 1'b1;
                    end
                    ST_SRWR: srd_q <= rx_byte;
                    default: ;
                endcase
            end
            if (cs_rise && state_q == ST_ARMED) begin
                case (op_q)
                    OP_WREN:   begin srv_q <= 1'b1; srk_q <= SRK_SET;    end
                    OP_WRDI:   begin srv_q <= 1'b1; srk_q <= SRK_CLR;    end
                    OP_WRSR:   begin srv_q <= 1'b1; srk_q <= SRK_WRITE;  end
                    OP_STORE:  begin nvv_q <= 1'b1; nvk_q <= NVK_STORE;  end
                    OP_RECALL: begin nvv_q <= 1'b1; nvk_q <= NVK_RECALL; end
                    OP_ASON:   begin nvv_q <= 1'b1; nvk_q <= NVK_ASON;   end
                    OP_ASOFF:  begin nvv_q <= 1'b1; nvk_q <= NVK_ASOFF;  end
                    default: ;
                endcase
            end
        end
    end

    assign mem_addr     = addr_q;
    assign mem_rd_en    = rd_q;
    assign mem_wr_en    = wr_q;
    assign mem_wdata    = wdata_q;
    assign sr_req_valid = srv_q;
    assign sr_req_kind  = srk_q;
    assign sr_req_data  = srd_q;
    assign nv_req_valid = nvv_q;
    assign nv_req_kind  = nvk_q;

    // R6: a cycle never both reads and writes memory
    p_wrrd_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_q && rd_q));

    // R7: the address steps by one, modulo the address space, after a write
    p_wr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |=> (addr_q == ($past(addr_q) + ADDR_W'(1))));

    // R3: requests appear only right after a chip-select rise
    p_req_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_q || nvv_q) |-> $past(cs_rise));

    // R10: at most one request per command
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(srv_q && nvv_q));

endmodule

// File: rtl/spi_nv_engine.sv
module spi_nv_engine #(
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        sr_rdata,
    output logic              sr_req_valid,
    output logic [1:0]        sr_req_kind,
    output logic [7:0]        sr_req_data,
    output logic              nv_req_valid,
    output logic [1:0]        nv_req_kind
);
    localparam int BYTE_W = 8;

    logic              cs_fall, cs_rise, sck_rise, sck_fall, si_s;
    logic              selected, hold_on;
    logic              byte_done, ld;
    logic [BYTE_W-1:0] rx_byte, ld_data;

    spi_nv_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .hold_n   (hold_n),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s),
        .selected (selected),
        .hold_on  (hold_on)
    );

    spi_nv_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cs_fall),
        .rise      (sck_rise),
        .fall      (sck_fall),
        .si        (si_s),
        .ld        (ld),
        .ld_data   (ld_data),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .so_bit    (so)
    );

    spi_nv_ctrl #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_fall      (cs_fall),
        .cs_rise      (cs_rise),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .hold_on      (hold_on),
        .mem_rdata    (mem_rdata),
        .sr_rdata     (sr_rdata),
        .ld           (ld),
        .ld_data      (ld_data),
        .so_oe        (so_oe),
        .mem_addr     (mem_addr),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_wdata    (mem_wdata),
        .sr_req_valid (sr_req_valid),
        .sr_req_kind  (sr_req_kind),
        .sr_req_data  (sr_req_data),
        .nv_req_valid (nv_req_valid),
        .nv_req_kind  (nv_req_kind)
    );

    // R2: the output is never enabled while deselected
    p_no_oe_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |-> !so_oe);

    // R2: no memory write is started while deselected
    p_no_wr_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |-> !byte_done);

endmodule

// File: tb/spi_nv_engine_tb.sv
module spi_nv_engine_tb;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, mem_rd_en, mem_wr_en, sr_req_valid, nv_req_valid;
    logic [16:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00, mem_wdata, sr_req_data;
    logic [7:0]  sr_rdata = 8'h00;
    logic [1:0]  sr_req_kind, nv_req_kind;
    logic        mode3 = 1'b0;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [1:0]  typ;
        logic [16:0] a;
        logic [7:0]  d;
    } ev_t;

    ev_t   expq[$];
    string tagq[$];
    logic [7:0] bmem   [int];
    logic [7:0] shadow [int];

    always #2.5 clk = ~clk;

    spi_nv_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .sr_rdata(sr_rdata), .sr_req_valid(sr_req_valid), .sr_req_kind(sr_req_kind),
        .sr_req_data(sr_req_data), .nv_req_valid(nv_req_valid), .nv_req_kind(nv_req_kind)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] exp_byte(input int a);
        return shadow.exists(a) ? shadow[a] : pat(a);
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr_en) bmem[int'(mem_addr)] = mem_wdata;
        if (mem_rd_en)
            mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : pat(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_ev(input logic [1:0] typ, input logic [16:0] a,
                           input logic [7:0] d, input string tag);
        ev_t e;
        e.typ = typ; e.a = a; e.d = d;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic got_ev(input ev_t e);
        ev_t   x;
        string t;
        if (expq.size() == 0) begin
            chk(1'b0, "unexpected event", int'(e), 0);
        end else begin
            x = expq.pop_front();
            t = tagq.pop_front();
            chk(x == e, t, int'(e), int'(x));
        end
    endtask

    // monitor: 0 memory write, 1 status request, 2 nonvolatile request
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr_en) got_ev({2'd0, mem_addr, mem_wdata});
            if (sr_req_valid)
                got_ev({2'd1, 15'd0, sr_req_kind, (sr_req_kind == 2'd2) ? sr_req_data : 8'h00});
            if (nv_req_valid) got_ev({2'd2, 15'd0, nv_req_kind, 8'h00});
        end
    end

    task automatic cw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        cw(20);
        chk(expq.size() == 0, tag, expq.size(), 0);
        expq.delete();
        tagq.delete();
    endtask

    task automatic cs_begin();
        sck = mode3; cw(4); cs_n = 1'b0; cw(HALF);
    endtask

    task automatic cs_end();
        cw(HALF); cs_n = 1'b1; cw(HALF); sck = mode3; cw(4);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        output logic [7:0] rx, output logic oe_any);
        rx = '0; oe_any = 1'b0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sck = 1'b0; si = tx[i]; cw(HALF);
            if (i == hold_at) begin
                hold_n = 1'b0; cw(3);
                chk(so_oe == 1'b0, "R11 hold output off", so_oe, 0);
                for (int k = 0; k < 2; k++) begin
                    si = ~si; sck = 1'b1; cw(HALF); sck = 1'b0; cw(HALF);
                end
                si = tx[i]; hold_n = 1'b1; cw(HALF);
            end
            rx[i] = so;
            if (so_oe) oe_any = 1'b1;
            sck = 1'b1; cw(HALF);
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        logic       o;
        xfer(b, 8, -1, r, o);
    endtask

    task automatic do_simple(input logic [7:0] op, input logic [1:0] typ,
                             input logic [1:0] kind, input string tag);
        push_ev(typ, {15'd0, kind}, 8'h00, tag);
        cs_begin(); send(op); cs_end();
        drained(tag);
    endtask

    task automatic do_write(input logic [23:0] a, input logic [31:0] dat, input int n,
                            input int hb, input int hbit, input string tag);
        logic [16:0] p;
        logic [7:0]  b, r;
        logic        o;
        p = a[16:0];
        cs_begin();
        send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
        for (int k = 0; k < n; k++) begin
            b = dat[31 - 8*k -: 8];
            push_ev(2'd0, p, b, tag);
            shadow[int'(p)] = b;
            p = p + 17'd1;
            xfer(b, 8, (k == hb) ? hbit : -1, r, o);
        end
        cs_end();
        drained(tag);
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input int hb,
                           input int hbit, input string tag);
        logic [16:0] p;
        logic [7:0]  r;
        logic        o;
        p = a[16:0];
        cs_begin();
        send(8'h03); send(a[23:16]); send(a[15:8]); send(a[7:0]);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, (k == hb) ? hbit : -1, r, o);
            chk(o && (r == exp_byte(int'(p))), tag, {o, r}, {1'b1, exp_byte(int'(p))});
            p = p + 17'd1;
        end
        cs_end();
        drained(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       o;
        cw(5);
        rst_n = 1'b1;
        cw(3);
        // R1: reset state
        chk(!so_oe && !mem_wr_en && !mem_rd_en && !sr_req_valid && !nv_req_valid,
            "R1 reset outputs", {so_oe, mem_wr_en, mem_rd_en}, 0);
        // R1: chip select low since reset, command must be ignored
        send(8'h06); send(8'h3C);
        cw(HALF); cs_n = 1'b1; cw(HALF); sck = 1'b0; cw(4);
        drained("R1 no command before first fall");

        // R2: deselected activity
        for (int k = 0; k < 8; k++) begin
            si = k[0]; sck = 1'b1; cw(HALF);
            chk(so_oe == 1'b0, "R2 deselected oe", so_oe, 0);
            sck = 1'b0; cw(HALF);
        end
        drained("R2 deselected no events");

        // R3: opcode-only commands
        do_simple(8'h06, 2'd1, 2'd0, "R3 set wen");
        do_simple(8'h04, 2'd1, 2'd1, "R3 clear wen");
        do_simple(8'h3C, 2'd2, 2'd0, "R3 store");
        do_simple(8'h60, 2'd2, 2'd1, "R3 recall");
        do_simple(8'h59, 2'd2, 2'd2, "R3 autostore on");
        do_simple(8'h19, 2'd2, 2'd3, "R3 autostore off");

        // R4: status write and repeated status read
        push_ev(2'd1, 17'd2, 8'hB4, "R4 status write");
        cs_begin(); send(8'h01); send(8'hB4); cs_end();
        drained("R4 status write");
        sr_rdata = 8'hC3;
        cs_begin(); send(8'h05);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, 8, -1, r, o);
            chk(o && r == 8'hC3, "R4 status read", {o, r}, {1'b1, 8'hC3});
        end
        cs_end();

        // R6 / R5: burst write and read back
        do_write(24'h000120, 32'h11223300, 3, -1, -1, "R6 burst write");
        do_read(24'h000120, 4, -1, -1, "R5 burst read");
        do_read(24'hFE0120, 1, -1, -1, "R5 high address bits ignored");

        // R7: wrap from the top address
        do_write(24'hFFFFFF, 32'h5AA50000, 2, -1, -1, "R7 write wrap");
        do_read(24'h01FFFF, 2, -1, -1, "R7 read wrap");

        // R8: aborted bytes
        cs_begin(); xfer(8'h06, 5, -1, r, o); cs_end();
        drained("R8 partial opcode");
        cs_begin(); send(8'h01); xfer(8'h80, 3, -1, r, o); cs_end();
        drained("R8 partial status byte");
        push_ev(2'd0, 17'h00200, 8'h77, "R8 partial write byte");
        shadow[32'h200] = 8'h77;
        cs_begin(); send(8'h02); send(8'h00); send(8'h02); send(8'h00);
        send(8'h77); xfer(8'hEE, 4, -1, r, o); cs_end();
        drained("R8 partial write byte");

        // R9: reserved and unknown opcodes
        cs_begin(); send(8'h1E); xfer(8'h06, 8, -1, r, o); cs_end();
        chk(o == 1'b0, "R9 reserved opcode oe", o, 0);
        drained("R9 reserved opcode");
        cs_begin(); send(8'hFF); xfer(8'h3C, 8, -1, r, o); cs_end();
        chk(o == 1'b0, "R9 unknown opcode oe", o, 0);
        drained("R9 unknown opcode");

        // R10: one opcode per selection
        push_ev(2'd1, 17'd0, 8'h00, "R10 single opcode");
        cs_begin(); send(8'h06); send(8'h3C); send(8'h60); cs_end();
        drained("R10 single opcode");

        // R11: hold pauses in write and read
        do_write(24'h000300, 32'h96C30000, 2, 0, 3, "R11 hold in write");
        do_read(24'h000300, 2, 1, 5, "R11 hold in read");

        // R12: mode 3
        mode3 = 1'b1;
        sck = 1'b1; cw(4);
        do_simple(8'h3C, 2'd2, 2'd0, "R12 mode3 store");
        do_write(24'h000400, 32'hA1B2C300, 3, -1, -1, "R12 mode3 write");
        do_read(24'h000400, 3, -1, -1, "R12 mode3 read");
        mode3 = 1'b0;
        sck = 1'b0; cw(4);
        do_read(24'h000401, 1, -1, -1, "R12 mode0 after mode3");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule